// File: doc/BRIEF.md
# Single-Line MSI Snooping Cache Cluster

This block groups a parameterised number of processor-side cache controllers. Each controller keeps one line: an address tag, a data word and a coherence mode (invalid, shared or modified). The controllers share one atomic snoop bus and a word-addressed main memory. Each processor port offers requests through a valid/ready handshake. A round-robin arbiter picks at most one request per cycle. That request is carried out as a complete bus transaction at the next clock edge. Every cache and the memory see the whole transaction within that edge, so no other transaction can overlap it.

On a read miss, a modified victim is first written back. The missing word is then fetched from memory, or from another cache that holds it modified. In that second case the owner also refreshes memory and drops to shared. A write always leaves the writer's line modified. Writes that need ownership invalidate all other copies, and an invalidated line is cleared to address 0 and data 0. Each accepted request is answered by a one-cycle response pulse with data in the following cycle. The line state of every controller is brought out on ports for the integration checks.

Top module: `msi_snoop_sys`

## Requirements
- R1: After reset every line reads mode 0 (invalid), tag 0 and data 0, memory holds 0 at every address, and no response is pending.
- R2: A port's accepted request (req_valid and req_ready both high at an edge) yields rsp_valid high for exactly the next cycle, and req_ready of that port stays low while its rsp_valid is high.
- R3: At most one req_ready is high in a cycle. Grants rotate round-robin: the search starts at the port after the last one granted.
- R4: A read whose address matches a non-invalid line returns that line's data and changes no line and no memory word.
- R5: A read miss writes a modified victim back to memory. It then installs the address in mode 1 (shared), with data from memory when no other cache holds the address modified, and returns that data.
- R6: When a bus read hits a line in mode 2 (modified) in another cache, that cache supplies the data to the requester, memory is updated with it, and the owner drops to mode 1.
- R7: A write hit leaves the line in mode 2 holding the new data. If the line was shared, every other copy of that address is invalidated.
- R8: A write miss writes a modified victim back, installs the new address and data in mode 2, and invalidates the address in every other cache.
- R9: An invalidated line has mode 0, tag 0 and data 0.
- R10: No address is ever held in mode 2 by one cache while another cache holds it in mode 1 or 2.
- R11: A write response returns the written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_CACHES | Request offered per port |
| req_write | input | N_CACHES | 1 = write, 0 = read, per port |
| req_addr | input | N_CACHES*ADDR_W | Request address, port p at bits [p*ADDR_W +: ADDR_W] |
| req_wdata | input | N_CACHES*DATA_W | Write data per port |
| req_ready | output | N_CACHES | Request accepted at the coming edge |
| rsp_valid | output | N_CACHES | One-cycle response pulse per port |
| rsp_data | output | N_CACHES*DATA_W | Response data per port |
| line_mode | output | N_CACHES*2 | Line mode per cache: 0 invalid, 1 shared, 2 modified |
| line_tag | output | N_CACHES*ADDR_W | Line address per cache |
| line_data | output | N_CACHES*DATA_W | Line data per cache |

## Verification
The assertions check the following on every cycle: the single-grant rule, the handshake and response timing, the cleared contents of invalid lines, that read hits leave the line unchanged, that a snooped modified owner demotes to shared, and the cross-cache exclusivity of the modified mode. Other properties need a model that follows the data across transactions, so only the bench's request streams can show them. These are the values that write-backs and cache-to-cache supply leave in memory, the data a later miss returns, and whether the round-robin order holds under continuous contention.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    MODE_INV = 2'd0,
    MODE_SHR = 2'd1,
    MODE_MOD = 2'd2
  } line_mode_e;
endpackage

// File: rtl/msi_rr_arb.sv
module msi_rr_arb #(
  parameter int N = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] grant_idx,
  output logic             grant_vld
);
  logic [IDX_W-1:0] ptr_q, ptr_d;
  int cand;

  always_comb begin
    grant     = '0;
    grant_idx = '0;
    grant_vld = 1'b0;
    cand      = 0;
    for (int k = 0; k < N; k++) begin
      cand = (int'(ptr_q) + k) % N;
      if (!grant_vld && req[cand]) begin
        grant_vld   = 1'b1;
        grant[cand] = 1'b1;
        grant_idx   = IDX_W'(cand);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (grant_vld) begin
      if (int'(grant_idx) == N - 1) ptr_d = '0;
      else                          ptr_d = grant_idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr_q <= '0;
    else if (grant_vld) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/msi_mem.sv
module msi_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wa_en,
  input  logic [ADDR_W-1:0] wa_addr,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_data
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rd_data = mem_q[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (wa_en) mem_q[wa_addr] <= wa_data;
      if (wb_en) mem_q[wb_addr] <= wb_data;
    end
  end

  // R5 R6: victim and owner write-backs never target the same word
  same_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && wb_en) |-> (wa_addr != wb_addr));
endmodule

// File: rtl/msi_line.sv
module msi_line
  import msi_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_en,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              snoop_rd,
  input  logic              snoop_inv,
  output line_mode_e        mode_o,
  output logic [ADDR_W-1:0] tag_o,
  output logic [DATA_W-1:0] data_o,
  output logic              hit_o
);
  line_mode_e        mode_q, mode_d;
  logic [ADDR_W-1:0] tag_q, tag_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              hit;

  assign hit = (mode_q != MODE_INV) && (tag_q == bus_addr);

  always_comb begin
    mode_d = mode_q;
    tag_d  = tag_q;
    data_d = data_q;
    if (req_en) begin
      if (req_write) begin
        mode_d = MODE_MOD;
        tag_d  = bus_addr;
        data_d = req_wdata;
      end else if (!hit) begin
        mode_d = MODE_SHR;
        tag_d  = bus_addr;
        data_d = fill_data;
      end
    end else if (snoop_inv && hit) begin
      mode_d = MODE_INV;
      tag_d  = '0;
      data_d = '0;
    end else if (snoop_rd && hit && mode_q == MODE_MOD) begin
      mode_d = MODE_SHR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_INV;
      tag_q  <= '0;
      data_q <= '0;
    end else begin
      mode_q <= mode_d;
      tag_q  <= tag_d;
      data_q <= data_d;
    end
  end

  assign mode_o = mode_q;
  assign tag_o  = tag_q;
  assign data_o = data_q;
  assign hit_o  = hit;

  // R4
  read_hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && !req_write && hit) |=>
      (mode_q == $past(mode_q) && data_q == $past(data_q) && tag_q == $past(tag_q)));
  // R6
  owner_demote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_en && snoop_rd && mode_q == MODE_MOD && tag_q == bus_addr) |=> (mode_q == MODE_SHR));
  // R7
  write_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && req_write) |=> (mode_q == MODE_MOD && tag_q == $past(bus_addr)));
  // R9
  inv_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_INV) |-> (tag_q == '0 && data_q == '0));
endmodule

// File: rtl/msi_snoop_sys.sv
module msi_snoop_sys
  import msi_pkg::*;
#(
  parameter int N_CACHES = 3,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = (N_CACHES > 1) ? $clog2(N_CACHES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_CACHES-1:0]          req_valid,
  input  logic [N_CACHES-1:0]          req_write,
  input  logic [N_CACHES*ADDR_W-1:0]   req_addr,
  input  logic [N_CACHES*DATA_W-1:0]   req_wdata,
  output logic [N_CACHES-1:0]          req_ready,
  output logic [N_CACHES-1:0]          rsp_valid,
  output logic [N_CACHES*DATA_W-1:0]   rsp_data,
  output logic [N_CACHES*2-1:0]        line_mode,
  output logic [N_CACHES*ADDR_W-1:0]   line_tag,
  output logic [N_CACHES*DATA_W-1:0]   line_data
);
  logic [N_CACHES-1:0] eligible, grant, hit;
  logic [IDX_W-1:0]    gidx;
  logic                gvld;
  line_mode_e          mode_w [N_CACHES];
  logic [ADDR_W-1:0]   tag_w  [N_CACHES];
  logic [DATA_W-1:0]   data_w [N_CACHES];
  logic [N_CACHES-1:0] rsp_vq;
  logic [DATA_W-1:0]   rsp_dq [N_CACHES];
  logic [DATA_W-1:0]   rsp_dd;

  logic              rq_write, own_hit, bus_rd, bus_inv, owner_found, victim_wb;
  logic [ADDR_W-1:0] rq_addr;
  logic [DATA_W-1:0] rq_wdata, owner_data, mem_rd, fill;
  line_mode_e        own_mode;

  assign eligible = req_valid & ~rsp_vq;

  msi_rr_arb #(.N(N_CACHES)) i_arb (
    .clk(clk), .rst_n(rst_n), .req(eligible),
    .grant(grant), .grant_idx(gidx), .grant_vld(gvld)
  );

  assign req_ready = grant;

  // granted request and requester line view
  assign rq_write = req_write[gidx];
  assign rq_addr  = req_addr[gidx*ADDR_W +: ADDR_W];
  assign rq_wdata = req_wdata[gidx*DATA_W +: DATA_W];
  assign own_hit  = hit[gidx];
  assign own_mode = mode_w[gidx];

  assign bus_rd  = gvld && !rq_write && !own_hit;
  assign bus_inv = gvld && rq_write && !(own_hit && own_mode == MODE_MOD);
  assign victim_wb = gvld && !own_hit && own_mode == MODE_MOD;

  always_comb begin
    owner_found = 1'b0;
    owner_data  = '0;
    for (int i = 0; i < N_CACHES; i++) begin
      if (i != int'(gidx) && hit[i] && mode_w[i] == MODE_MOD) begin
        owner_found = 1'b1;
        owner_data  = data_w[i];
      end
    end
  end

  assign fill = owner_found ? owner_data : mem_rd;

  msi_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(rq_addr), .rd_data(mem_rd),
    .wa_en(victim_wb), .wa_addr(tag_w[gidx]), .wa_data(data_w[gidx]),
    .wb_en(bus_rd && owner_found), .wb_addr(rq_addr), .wb_data(owner_data)
  );

  generate
    for (genvar c = 0; c < N_CACHES; c++) begin : g_line
      msi_line #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_line (
        .clk(clk), .rst_n(rst_n),
        .req_en(grant[c]), .req_write(rq_write), .bus_addr(rq_addr),
        .req_wdata(rq_wdata), .fill_data(fill),
        .snoop_rd(bus_rd), .snoop_inv(bus_inv),
        .mode_o(mode_w[c]), .tag_o(tag_w[c]), .data_o(data_w[c]), .hit_o(hit[c])
      );
      assign line_mode[c*2 +: 2]          = mode_w[c];
      assign line_tag[c*ADDR_W +: ADDR_W] = tag_w[c];
      assign line_data[c*DATA_W +: DATA_W] = data_w[c];
      assign rsp_data[c*DATA_W +: DATA_W]  = rsp_dq[c];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rsp_dq[c] <= '0;
        else if (grant[c]) rsp_dq[c] <= rsp_dd;
      end
    end
  endgenerate

  always_comb begin
    if (rq_write)     rsp_dd = rq_wdata;
    else if (own_hit) rsp_dd = data_w[gidx];
    else              rsp_dd = fill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_vq <= '0;
    else        rsp_vq <= grant;
  end

  assign rsp_valid = rsp_vq;

  // exclusivity monitor over all line pairs
  logic coh_err;
  always_comb begin
    coh_err = 1'b0;
    for (int i = 0; i < N_CACHES; i++) begin
      for (int j = 0; j < N_CACHES; j++) begin
        if (i != j && mode_w[i] == MODE_MOD && mode_w[j] != MODE_INV &&
            tag_w[i] == tag_w[j])
          coh_err = 1'b1;
      end
    end
  end

  // R3
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  // R2
  busy_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid & req_ready) == '0);
  // R2
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(req_valid & req_ready) |=> (rsp_valid == $past(req_valid & req_ready)));
  // R10
  coherent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !coh_err);
endmodule

// File: tb/test_msi_snoop_sys.sv
`timescale 1ns/1ps
module test_msi_snoop_sys;
  localparam int N  = 3;
  localparam int AW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]    req_valid, req_write, req_ready, rsp_valid;
  logic [N*AW-1:0] req_addr, line_tag;
  logic [N*DW-1:0] req_wdata, rsp_data, line_data;
  logic [N*2-1:0]  line_mode;

  always #2.5 clk = ~clk;

  msi_snoop_sys #(.N_CACHES(N), .ADDR_W(AW), .DATA_W(DW)) i_msi_snoop_sys (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .line_mode(line_mode),
    .line_tag(line_tag), .line_data(line_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int m_mode[N], m_tag[N], m_data[N], m_mem[16];
  int m_rspv[N], m_rspd[N], m_ptr;
  string m_lk[N], m_rk[N];
  int pend[N], op_w[N], op_a[N], op_d[N];
  int c4 = 0, c5 = 0, c6 = 0, c7 = 0, c8 = 0, c9 = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_state();
    for (int i = 0; i < N; i++) begin
      chk(m_lk[i], $sformatf("mode[%0d]", i), int'(line_mode[i*2 +: 2]), m_mode[i]);
      chk(m_lk[i], $sformatf("tag[%0d]", i), int'(line_tag[i*AW +: AW]), m_tag[i]);
      chk(m_lk[i], $sformatf("data[%0d]", i), int'(line_data[i*DW +: DW]), m_data[i]);
      chk("R2", $sformatf("rsp_valid[%0d]", i), int'(rsp_valid[i]), m_rspv[i]);
      if (m_rspv[i] != 0)
        chk(m_rk[i], $sformatf("rsp_data[%0d]", i), int'(rsp_data[i*DW +: DW]), m_rspd[i]);
    end
  endtask

  task automatic model_step(int g);
    int hit, fill, own;
    for (int i = 0; i < N; i++) m_rspv[i] = 0;
    if (g < 0) return;
    m_rspv[g] = 1;
    hit = (m_mode[g] != 0 && m_tag[g] == op_a[g]) ? 1 : 0;
    if (op_w[g] == 0 && hit == 1) begin
      m_rspd[g] = m_data[g]; m_rk[g] = "R4"; m_lk[g] = "R4"; c4++;
      return;
    end
    if (hit == 0 && m_mode[g] == 2) m_mem[m_tag[g]] = m_data[g];
    if (op_w[g] == 0) begin
      own = -1;
      for (int j = 0; j < N; j++)
        if (j != g && m_mode[j] == 2 && m_tag[j] == op_a[g]) own = j;
      if (own >= 0) begin
        fill = m_data[own]; m_mem[op_a[g]] = fill; m_mode[own] = 1; m_lk[own] = "R6"; c6++;
      end else fill = m_mem[op_a[g]];
      m_mode[g] = 1; m_tag[g] = op_a[g]; m_data[g] = fill;
      m_rspd[g] = fill; m_rk[g] = (own >= 0) ? "R6" : "R5"; m_lk[g] = "R5"; c5++;
    end else begin
      if (hit == 0 || m_mode[g] == 1) begin
        for (int j = 0; j < N; j++)
          if (j != g && m_mode[j] != 0 && m_tag[j] == op_a[g]) begin
            m_mode[j] = 0; m_tag[j] = 0; m_data[j] = 0; m_lk[j] = "R9"; c9++;
          end
      end
      m_mode[g] = 2; m_tag[g] = op_a[g]; m_data[g] = op_d[g];
      m_rspd[g] = op_d[g]; m_rk[g] = "R11";
      if (hit == 1) begin m_lk[g] = "R7"; c7++; end
      else begin m_lk[g] = "R8"; c8++; end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int g, seed;
    seed = 7;
    rst_n = 1'b0; req_valid = '0; req_write = '0; req_addr = '0; req_wdata = '0;
    for (int i = 0; i < N; i++) begin
      m_mode[i] = 0; m_tag[i] = 0; m_data[i] = 0; m_rspv[i] = 0; m_rspd[i] = 0;
      m_lk[i] = "R1"; m_rk[i] = "R1"; pend[i] = 0; op_w[i] = 0; op_a[i] = 0; op_d[i] = 0;
    end
    for (int a = 0; a < 16; a++) m_mem[a] = 0;
    m_ptr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      compare_state();
      // stimulus: random phase, then all ports always requesting
      for (int p = 0; p < N; p++) begin
        if (pend[p] == 0 && m_rspv[p] == 0 &&
            (cyc >= 3000 || $urandom_range(0, 1) == 1)) begin
          pend[p] = 1;
          op_w[p] = $urandom_range(0, 2) == 0 ? 1 : 0;
          op_a[p] = $urandom_range(0, 3);
          op_d[p] = $urandom_range(1, 255);
        end
        req_valid[p] = (pend[p] != 0);
        req_write[p] = op_w[p][0];
        req_addr[p*AW +: AW]  = AW'(op_a[p]);
        req_wdata[p*DW +: DW] = DW'(op_d[p]);
      end
      #1;
      g = -1;
      for (int k = 0; k < N; k++) begin
        int c;
        c = (m_ptr + k) % N;
        if (g < 0 && pend[c] != 0 && m_rspv[c] == 0) g = c;
      end
      for (int p = 0; p < N; p++)
        chk("R3", $sformatf("req_ready[%0d]", p), int'(req_ready[p]), (p == g) ? 1 : 0);
      if (g >= 0) begin
        m_ptr = (g + 1) % N;
        model_step(g);
        pend[g] = 0;
      end else model_step(-1);
    end
    chk("R4", "read hits seen", (c4 > 0) ? 1 : 0, 1);
    chk("R5", "read misses seen", (c5 > 0) ? 1 : 0, 1);
    chk("R6", "owner supplies seen", (c6 > 0) ? 1 : 0, 1);
    chk("R7", "write hits seen", (c7 > 0) ? 1 : 0, 1);
    chk("R8", "write misses seen", (c8 > 0) ? 1 : 0, 1);
    chk("R9", "invalidations seen", (c9 > 0) ? 1 : 0, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule